// File: doc/BRIEF.md
# Byte FIFO Pair with Trigger Interrupts

This block sits between a host register port and a serial bus sequencer. It holds two byte queues. The host loads the transmit queue, and the sequencer drains it one byte at a time. The sequencer fills the receive queue, and the host drains it by reading a data register. Each queue has its own enable and its own programmable trigger level. A status word shows the fill level, the full flag and the empty flag of both queues.

Eight event flags share one interrupt status register. Writing a one to a flag clears it, and a one written in the same cycle that the flag's condition holds loses to the new event. The flags are:
- transmit almost-empty and receive almost-full, raised by the trigger comparisons;
- underrun and overrun, one of each per queue;
- an idle "leftover data" timeout, raised when bytes sit in the receive queue below its trigger;
- a transfer event, pulsed in by the sequencer.

An enable mask selects which flags drive the single interrupt line.

The register port is word-indexed by `reg_addr`:

| Index | Register | Access |
|-------|----------|--------|
| 0 | queue control | read/write |
| 1 | queue status | read only |
| 2 | interrupt mask | read/write |
| 3 | interrupt flags | write one to clear |
| 4 | transmit data | write only, reads 0 |
| 5 | receive data | a read pops one byte |
| 6 | idle limit | read/write |

Read data is combinational on `reg_addr`. A receive-data read pops its byte at the clock edge that ends the strobe.

Top module: `fifo_pair_irq`

## Requirements
- R1: Each queue holds 64 bytes in first-in first-out order. `seq_tx_data` shows the transmit head and `seq_tx_pop` removes it. A read of index 5 with `reg_rd` returns the receive head and removes it.
- R2: The status word (index 1) has the following fields, with all other bits zero:
  - transmit level in bits 6:0, transmit full at bit 7, transmit empty at bit 8;
  - receive level in bits 22:16, receive full at bit 23, receive empty at bit 24.
- R3: The control word (index 0) has the receive enable at bit 0 and the transmit enable at bit 1. It resets to 0. A queue whose enable is 0 is emptied at the next edge and discards pushes. Its pops return 0, and it raises no underrun or overrun.
- R4: In the control word the receive trigger level occupies bits 10:4 and the transmit trigger level occupies bits 22:16. All unlisted control bits read 0.
- R5: Flag bit 0 (transmit almost-empty) is set at any edge where the transmit queue is enabled and its level is at or below the transmit trigger.
- R6: Flag bit 1 (receive almost-full) is set at any edge where the receive queue is enabled and its level is at or above the receive trigger.
- R7: A write to index 4 while the transmit queue is full drops the byte, leaves the level at 64 and sets flag bit 3.
- R8: A sequencer pop of an empty transmit queue returns 0 on `seq_tx_data` and sets flag bit 2.
- R9: A sequencer push into a full receive queue drops the byte and sets flag bit 5.
- R10: A read of index 5 while the receive queue is empty returns 0 and sets flag bit 4.
- R11: The idle timeout works as follows:
  - An idle counter restarts on any receive push or pop request, or while the receive queue is empty or disabled. Otherwise it counts up to the idle limit (index 6, bits 7:0, reset value 0xF).
  - Flag bit 6 is set at an edge where the counter has reached the limit, the queue is non-empty and below its trigger, and there is no push or pop in that cycle.
- R12: A one-cycle pulse on `xfer_evt` sets flag bit 9.
- R13: Writing a mask to index 3 clears the flags whose mask bits are one. If a flag's set condition holds in the same cycle, the flag stays set. Bits 7, 8 and 10 and above read 0.
- R14: The interrupt mask (index 2) has writable bits 0, 1, 6 and 9 and resets to 0. `irq` is high whenever a flag is set together with its mask bit, so writing 0 to the mask silences `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at index 5) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on `reg_addr` |
| seq_tx_pop | input | 1 | Sequencer takes the transmit head |
| seq_tx_data | output | 8 | Transmit head byte, 0 when empty or disabled |
| seq_rx_push | input | 1 | Sequencer pushes a received byte |
| seq_rx_data | input | 8 | Received byte |
| xfer_evt | input | 1 | Transfer event pulse from the sequencer |
| irq | output | 1 | Interrupt line |

## Verification
- **Same-cycle results.** Read data and the transmit head are combinational. They are sampled a quarter period after the falling edge, before the edge that acts on the strobe.
- **One-edge results.** Queue levels, full and empty bits, and register contents change at the first rising edge after the stimulus. Each event flag appears one edge after the cycle in which its condition held.
- **Idle timeout.** With limit L, the timeout flag appears L+1 edges after the last push or pop.
- **Interrupt line.** `irq` follows the flags and the mask in the same cycle.

The bench's behavioural queue model applies each edge with the inputs that were held before it. Its outputs are compared at the same quarter-period point, so every result is checked in the exact cycle it is due.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

  // Register word indices
  localparam logic [2:0] IX_CTRL  = 3'd0;
  localparam logic [2:0] IX_STAT  = 3'd1;
  localparam logic [2:0] IX_MASK  = 3'd2;
  localparam logic [2:0] IX_FLAGS = 3'd3;
  localparam logic [2:0] IX_TXD   = 3'd4;
  localparam logic [2:0] IX_RXD   = 3'd5;
  localparam logic [2:0] IX_IDLE  = 3'd6;

  // Width of a level or trigger field in the register layout
  localparam int FLD_W = 7;

  // Flag bit positions
  localparam int F_TXAE  = 0;
  localparam int F_RXAF  = 1;
  localparam int F_TXUR  = 2;
  localparam int F_TXOR  = 3;
  localparam int F_RXUR  = 4;
  localparam int F_RXOR  = 5;
  localparam int F_TRAIL = 6;
  localparam int F_XFER  = 9;
  localparam int NFLAG   = 10;

  localparam logic [NFLAG-1:0] FLAG_IMPL = 10'h27F;
  localparam logic [NFLAG-1:0] MASK_IMPL = 10'h243;

  function automatic logic lvl_at_or_below(input logic [FLD_W-1:0] lvl,
                                           input logic [FLD_W-1:0] trig);
    return lvl <= trig;
  endfunction

  function automatic logic lvl_at_or_above(input logic [FLD_W-1:0] lvl,
                                           input logic [FLD_W-1:0] trig);
    return lvl >= trig;
  endfunction

  function automatic logic [31:0] pack_stat(input logic [FLD_W-1:0] tl,
                                            input logic tf, input logic te,
                                            input logic [FLD_W-1:0] rl,
                                            input logic rf, input logic re);
    return {7'b0, re, rf, rl, 7'b0, te, tf, tl};
  endfunction

endpackage

// File: rtl/fpi_byte_fifo.sv
module fpi_byte_fifo #(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              en,
  input  logic                              push,
  input  logic [DW-1:0]                     din,
  input  logic                              pop,
  output logic [DW-1:0]                     dout,
  output logic [$clog2(DEPTH+1)-1:0]        level,
  output logic                              full,
  output logic                              empty,
  output logic                              drop_evt,
  output logic                              starve_evt
);
  localparam int LW = $clog2(DEPTH+1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic acc_push, acc_pop;

  assign full       = (level == LW'(DEPTH));
  assign empty      = (level == '0);
  assign acc_push   = en && push && !full;
  assign acc_pop    = en && pop && !empty;
  assign drop_evt   = en && push && full;
  assign starve_evt = en && pop && empty;
  assign dout       = (en && !empty) ? mem[rptr] : '0;

  always_ff @(posedge clk) begin
    if (acc_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (!en) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (acc_push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (acc_pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      level <= level + LW'(acc_push) - LW'(acc_pop);
    end
  end

  // R1
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && push && !full && !pop |=> level == $past(level) + LW'(1));
  // R3
  disabled_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> level == '0);
  // R7
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && push && full && !pop |=> full);
  // R10
  empty_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && pop && empty && !push |=> empty);
endmodule

// File: rtl/fpi_idle_timer.sv
module fpi_idle_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          active,
  input  logic          nonempty,
  input  logic          below_trig,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW-1:0] cnt;

  assign fire = en && nonempty && !active && below_trig && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (!en || active || !nonempty) cnt <= '0;
    else if (cnt < limit)                cnt <= cnt + 1'b1;
  end

  // R11
  idle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> cnt == '0);
  // R11
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && nonempty && !active && (cnt < limit) |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/fpi_irq_regs.sv
module fpi_irq_regs #(
  parameter int              NF   = 10,
  parameter logic [NF-1:0]   IMPL = '1,
  parameter logic [NF-1:0]   MIMP = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  input  logic          mask_we,
  input  logic [NF-1:0] mask_wdata,
  output logic [NF-1:0] flags,
  output logic [NF-1:0] mask,
  output logic          irq
);
  assign irq = |(flags & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= '0;
    end else begin
      flags <= ((flags & ~clr_vec) | set_vec) & IMPL;
      if (mask_we) mask <= mask_wdata & MIMP;
    end
  end

  // R13
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |clr_vec |=> (flags & $past(clr_vec) & ~$past(set_vec)) == '0);
  // R13
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(set_vec & IMPL) |=> (flags & $past(set_vec & IMPL)) == $past(set_vec & IMPL));
  // R14
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);
endmodule

// File: rtl/fifo_pair_irq.sv
module fifo_pair_irq
  import fpi_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int DW     = 8,
  parameter int IDLE_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          seq_tx_pop,
  output logic [DW-1:0] seq_tx_data,
  input  logic          seq_rx_push,
  input  logic [DW-1:0] seq_rx_data,
  input  logic          xfer_evt,
  output logic          irq
);
  localparam int LW  = $clog2(DEPTH+1);
  localparam int TXI = 0;
  localparam int RXI = 1;
  localparam logic [IDLE_W-1:0] IDLE_RST = IDLE_W'(15);

  // control state
  logic              rx_en, tx_en;
  logic [FLD_W-1:0]  rx_trig, tx_trig;
  logic [IDLE_W-1:0] idle_lim;

  // queue array wiring (index TXI / RXI)
  logic [1:0]    f_en, f_push, f_pop, f_full, f_empty, f_drop, f_starve;
  logic [DW-1:0] f_din  [2];
  logic [DW-1:0] f_dout [2];
  logic [LW-1:0] f_lvl  [2];
  logic [FLD_W-1:0] tx_lvl_f, rx_lvl_f;

  // named events
  logic wr_txd, rd_rxd, wr_flags, rx_active, trail_fire;
  logic [NFLAG-1:0] set_vec, clr_vec, flags, mask;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata;
  assign wr_txd    = reg_wr && (reg_addr == IX_TXD);
  assign rd_rxd    = reg_rd && (reg_addr == IX_RXD);
  assign wr_flags  = reg_wr && (reg_addr == IX_FLAGS);
  assign rx_active = seq_rx_push || rd_rxd;

  always_comb begin
    f_en[TXI]   = tx_en;
    f_push[TXI] = wr_txd;
    f_din[TXI]  = reg_wdata[DW-1:0];
    f_pop[TXI]  = seq_tx_pop;
    f_en[RXI]   = rx_en;
    f_push[RXI] = seq_rx_push;
    f_din[RXI]  = seq_rx_data;
    f_pop[RXI]  = rd_rxd;
  end

  for (genvar g = 0; g < 2; g++) begin : g_q
    fpi_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .en         (f_en[g]),
      .push       (f_push[g]),
      .din        (f_din[g]),
      .pop        (f_pop[g]),
      .dout       (f_dout[g]),
      .level      (f_lvl[g]),
      .full       (f_full[g]),
      .empty      (f_empty[g]),
      .drop_evt   (f_drop[g]),
      .starve_evt (f_starve[g])
    );
  end

  assign tx_lvl_f    = FLD_W'(f_lvl[TXI]);
  assign rx_lvl_f    = FLD_W'(f_lvl[RXI]);
  assign seq_tx_data = f_dout[TXI];

  fpi_idle_timer #(.CW(IDLE_W)) u_idle (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (rx_en),
    .active     (rx_active),
    .nonempty   (!f_empty[RXI]),
    .below_trig (rx_lvl_f < rx_trig),
    .limit      (idle_lim),
    .fire       (trail_fire)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[F_TXAE]  = tx_en && lvl_at_or_below(tx_lvl_f, tx_trig);
    set_vec[F_RXAF]  = rx_en && lvl_at_or_above(rx_lvl_f, rx_trig);
    set_vec[F_TXUR]  = f_starve[TXI];
    set_vec[F_TXOR]  = f_drop[TXI];
    set_vec[F_RXUR]  = f_starve[RXI];
    set_vec[F_RXOR]  = f_drop[RXI];
    set_vec[F_TRAIL] = trail_fire;
    set_vec[F_XFER]  = xfer_evt;
    clr_vec          = wr_flags ? reg_wdata[NFLAG-1:0] : '0;
  end

  fpi_irq_regs #(.NF(NFLAG), .IMPL(FLAG_IMPL), .MIMP(MASK_IMPL)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .mask_we    (reg_wr && (reg_addr == IX_MASK)),
    .mask_wdata (reg_wdata[NFLAG-1:0]),
    .flags      (flags),
    .mask       (mask),
    .irq        (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en    <= 1'b0;
      tx_en    <= 1'b0;
      rx_trig  <= '0;
      tx_trig  <= '0;
      idle_lim <= IDLE_RST;
    end else if (reg_wr) begin
      if (reg_addr == IX_CTRL) begin
        rx_en   <= reg_wdata[0];
        tx_en   <= reg_wdata[1];
        rx_trig <= reg_wdata[4 +: FLD_W];
        tx_trig <= reg_wdata[16 +: FLD_W];
      end
      if (reg_addr == IX_IDLE) idle_lim <= reg_wdata[IDLE_W-1:0];
    end
  end

  always_comb begin
    case (reg_addr)
      IX_CTRL:  reg_rdata = {9'b0, tx_trig, 5'b0, rx_trig, 2'b0, tx_en, rx_en};
      IX_STAT:  reg_rdata = pack_stat(tx_lvl_f, f_full[TXI], f_empty[TXI],
                                      rx_lvl_f, f_full[RXI], f_empty[RXI]);
      IX_MASK:  reg_rdata = 32'(mask);
      IX_FLAGS: reg_rdata = 32'(flags);
      IX_RXD:   reg_rdata = 32'(f_dout[RXI]);
      IX_IDLE:  reg_rdata = 32'(idle_lim);
      default:  reg_rdata = '0;
    endcase
  end

  // R12
  xfer_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_evt |=> flags[F_XFER]);
  // R5
  tx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en && (tx_lvl_f <= tx_trig) |=> flags[F_TXAE]);
  // R6
  rx_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && (rx_lvl_f >= rx_trig) |=> flags[F_RXAF]);
  // R9
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && seq_rx_push && f_full[RXI] |=> flags[F_RXOR]);
endmodule

// File: tb/fifo_pair_irq_tb.sv
module fifo_pair_irq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        seq_tx_pop = 1'b0;
  logic [7:0]  seq_tx_data;
  logic        seq_rx_push = 1'b0;
  logic [7:0]  seq_rx_data = '0;
  logic        xfer_evt = 1'b0;
  logic        irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fifo_pair_irq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .seq_tx_pop(seq_tx_pop), .seq_tx_data(seq_tx_data),
    .seq_rx_push(seq_rx_push), .seq_rx_data(seq_rx_data),
    .xfer_evt(xfer_evt), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0]  txq [$];
  logic [7:0]  rxq [$];
  logic [31:0] m_ctrl;
  logic [9:0]  m_mask, m_flags, m_set, m_clr;
  logic [7:0]  m_lim;
  int          tcnt, ptx, prx, txt, rxt;
  bit          ten, ren, act;

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_ctrl = 0; m_mask = 0; m_flags = 0; m_lim = 8'h0F; tcnt = 0;
    end else begin
      ptx = txq.size(); prx = rxq.size();
      ren = m_ctrl[0]; ten = m_ctrl[1];
      rxt = int'(m_ctrl[10:4]); txt = int'(m_ctrl[22:16]);
      m_set = 0; m_clr = 0;
      if (ten) begin
        if (seq_tx_pop) begin
          if (ptx == 0) m_set[2] = 1; else void'(txq.pop_front());
        end
        if (reg_wr && reg_addr == 3'd4) begin
          if (ptx == 64) m_set[3] = 1; else txq.push_back(reg_wdata[7:0]);
        end
        if (ptx <= txt) m_set[0] = 1;
      end else txq.delete();
      if (ren) begin
        if (reg_rd && reg_addr == 3'd5) begin
          if (prx == 0) m_set[4] = 1; else void'(rxq.pop_front());
        end
        if (seq_rx_push) begin
          if (prx == 64) m_set[5] = 1; else rxq.push_back(seq_rx_data);
        end
        if (prx >= rxt) m_set[1] = 1;
      end else rxq.delete();
      act = seq_rx_push || (reg_rd && reg_addr == 3'd5);
      if (ren && prx != 0 && !act && prx < rxt && tcnt >= int'(m_lim)) m_set[6] = 1;
      if (!ren || act || prx == 0) tcnt = 0;
      else if (tcnt < int'(m_lim)) tcnt++;
      if (xfer_evt) m_set[9] = 1;
      if (reg_wr && reg_addr == 3'd3) m_clr = reg_wdata[9:0];
      m_flags = (m_flags & ~m_clr) | m_set;
      if (reg_wr && reg_addr == 3'd0) m_ctrl = reg_wdata & 32'h007F_07F3;
      if (reg_wr && reg_addr == 3'd2) m_mask = reg_wdata[9:0] & 10'h243;
      if (reg_wr && reg_addr == 3'd6) m_lim = reg_wdata[7:0];
    end
  end

  function automatic logic [31:0] m_stat();
    logic [31:0] s = 0;
    s[6:0]   = 7'(txq.size());
    s[7]     = (txq.size() == 64);
    s[8]     = (txq.size() == 0);
    s[22:16] = 7'(rxq.size());
    s[23]    = (rxq.size() == 64);
    s[24]    = (rxq.size() == 0);
    return s;
  endfunction

  function automatic logic [31:0] m_rdata(input logic [2:0] a);
    case (a)
      3'd0: return m_ctrl;
      3'd1: return m_stat();
      3'd2: return {22'b0, m_mask};
      3'd3: return {22'b0, m_flags};
      3'd5: return (m_ctrl[0] && rxq.size() > 0) ? {24'b0, rxq[0]} : 32'b0;
      3'd6: return {24'b0, m_lim};
      default: return 32'b0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
    total++;
    if (act_v !== exp_v) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n && !done) begin
      case (reg_addr)
        3'd0:    check("R3/R4 ctrl readback", reg_rdata, m_rdata(reg_addr));
        3'd1:    check("R2 status word", reg_rdata, m_rdata(reg_addr));
        3'd2:    check("R14 mask readback", reg_rdata, m_rdata(reg_addr));
        3'd3:    check("R13 flags readback", reg_rdata, m_rdata(reg_addr));
        3'd5:    check("R1 rx head", reg_rdata, m_rdata(reg_addr));
        3'd6:    check("R11 idle limit", reg_rdata, m_rdata(reg_addr));
        default: check("R2 unused index", reg_rdata, m_rdata(reg_addr));
      endcase
      check("R1 tx head", {24'b0, seq_tx_data},
            (m_ctrl[1] && txq.size() > 0) ? {24'b0, txq[0]} : 32'b0);
      check("R14 irq line", {31'b0, irq}, {31'b0, |(m_flags & m_mask)});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rxpush(input logic [7:0] d);
    seq_rx_push = 1; seq_rx_data = d;
    @(negedge clk); seq_rx_push = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  logic [31:0] v;

  initial begin
    #(CLK_PERIOD*150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=finished");
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    peek(3'd1, v); check("R2 reset status", v, 32'h0100_0100);
    peek(3'd0, v); check("R3 reset ctrl", v, 32'h0);
    peek(3'd6, v); check("R11 reset limit", v, 32'h0F);
    peek(3'd3, v); check("R13 reset flags", v, 32'h0);
    check("R14 reset irq", {31'b0, irq}, 32'h0);

    // enable both, rx trig 4, tx trig 2
    wr(3'd0, 32'h0002_0043);
    peek(3'd0, v); check("R4 trigger fields", v, 32'h0002_0043);
    for (int i = 0; i < 64; i++) wr(3'd4, 32'h30 + i);
    peek(3'd1, v); check("R2 tx full status", v, 32'h0100_00C0);
    wr(3'd4, 32'hEE);
    peek(3'd3, v); check("R7 tx overrun flag", (v >> 3) & 1, 1);
    peek(3'd1, v); check("R7 level held", v, 32'h0100_00C0);
    check("R1 tx first byte", {24'b0, seq_tx_data}, 32'h30);
    for (int i = 0; i < 64; i++) begin
      seq_tx_pop = 1; #1;
      check("R1 tx order", {24'b0, seq_tx_data}, 32'h30 + i);
      @(negedge clk);
    end
    #1; check("R8 empty head zero", {24'b0, seq_tx_data}, 0);
    @(negedge clk); seq_tx_pop = 0;
    peek(3'd3, v); check("R8 tx underrun flag", (v >> 2) & 1, 1);
    peek(3'd3, v); check("R5 tx almost-empty", v & 1, 1);

    // disable tx: writes discarded, no overrun
    wr(3'd0, 32'h0002_0041);
    wr(3'd3, 32'h3FF);
    for (int i = 0; i < 3; i++) wr(3'd4, 32'h77);
    peek(3'd3, v); check("R13 cleared flags", v, 0);
    peek(3'd1, v); check("R3 disabled tx empty", v, 32'h0100_0100);

    // set wins over clear
    wr(3'd0, 32'h0002_0043);
    wr(3'd3, 32'h1);
    peek(3'd3, v); check("R13 set wins", v & 1, 1);

    // trailing data and almost-full
    rxpush(8'hA0); rxpush(8'hA1); rxpush(8'hA2);
    idle(5);
    peek(3'd3, v); check("R11 no early timeout", (v >> 6) & 1, 0);
    check("R6 below trigger", (v >> 1) & 1, 0);
    idle(20);
    peek(3'd3, v); check("R11 timeout flag", (v >> 6) & 1, 1);
    rxpush(8'hA3);
    idle(2);
    peek(3'd3, v); check("R6 almost-full flag", (v >> 1) & 1, 1);
    for (int i = 0; i < 4; i++) begin
      reg_rd = 1; reg_addr = 3'd5; #1;
      check("R1 rx order", reg_rdata, 32'hA0 + i);
      @(negedge clk);
    end
    #1; check("R10 empty read zero", reg_rdata, 0);
    @(negedge clk); reg_rd = 0;
    peek(3'd3, v); check("R10 rx underrun flag", (v >> 4) & 1, 1);

    // rx overrun
    for (int i = 0; i < 65; i++) rxpush(8'(i));
    peek(3'd3, v); check("R9 rx overrun flag", (v >> 5) & 1, 1);
    peek(3'd1, v); check("R9 rx full status", (v >> 16) & 32'h1FF, 32'h0C0);

    // transfer event and mask
    wr(3'd2, 32'h200);
    wr(3'd3, 32'h3FF);
    check("R14 masked flags", {31'b0, irq}, 0);
    xfer_evt = 1; @(negedge clk); xfer_evt = 0;
    peek(3'd3, v); check("R12 xfer flag", (v >> 9) & 1, 1);
    check("R14 irq raised", {31'b0, irq}, 1);
    wr(3'd2, 32'h0);
    check("R14 mask zero silences", {31'b0, irq}, 0);

    // zero idle limit
    wr(3'd0, 32'h0002_0042);
    wr(3'd0, 32'h0002_0043);
    wr(3'd6, 32'h0);
    wr(3'd3, 32'h3FF);
    rxpush(8'h55);
    idle(2);
    peek(3'd3, v); check("R11 zero limit timeout", (v >> 6) & 1, 1);
    idle(2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule